// File: doc/BRIEF.md
# Eight-to-One Pixel Serializer with Sync Control

This block sits between a frame-buffer read pipeline and a triple video converter. Upstream logic delivers a wide word that holds eight 24-bit RGB pixels. The block captures that word, together with the blank and sync controls, when the load strobe rises. It then sends the eight pixels out one per fast pixel clock, always in the same order. It also produces the divided load-out clock, one eighth of the pixel rate, which the upstream logic uses to pace its word reads.

Each output sample carries three 8-bit colour codes, a per-channel blank flag and a per-channel sync flag. A five-bit configuration input selects which colour channels carry composite sync and whether the sync and blank flags are inverted. The words are double-buffered. A capture that lands in the middle of a group waits until the current group has finished shifting out.

The sequence stays idle and blanked until a restart control bit goes from low to high. Every such rising transition restarts the sequence at the first pixel. The fast clock is a plain clock input, and the load strobe is a level sampled on that clock.

Top module: `pixel_serializer`

## Requirements
- R1: During reset, and on every cycle before the first rising transition of `seq_restart`, the colour outputs are zero, `sync_o`, `hsync_o`, `vsync_o` and `load_out` are low, and the phase stays at the first pixel. During reset `blank_o` is 3'b111. While idle it is the asserted blank level, which is all bits equal to the inverse of `sync_cfg[1]`.
- R2: `load_in` is sampled on `clk_pix`. On the edge where it is first seen high after being low, the block captures `pix_word` together with `blank_in`, `hsync_in`, `vsync_in` and `csync_in` as one group.
- R3: Pixel k (k = 0..7, called A..H) sits in `pix_word[24k+23:24k]`, with red in bits 23:16, green in bits 15:8 and blue in bits 7:0 of that slice. While running, one pixel is emitted per clock in the order A to H, then the sequence repeats. Every output is registered.
- R4: A rising transition of `seq_restart`, as seen on a clock edge, starts a new group. The most recently captured group is loaded, and pixel A appears at the outputs after the following edge. This holds even in the middle of a group.
- R5: `load_out` is low while idle. While running, it is high during the four cycles in which the phase is at A to D and low during the four cycles at E to H. This gives a period of eight pixel clocks.
- R6: The group being shifted out changes only at a group boundary: after H is selected, or on a restart. It then takes the latest capture, so a capture made in the middle of a group never alters the pixels of the current group.
- R7: When the captured blank is high, all three colour codes are zero. The blank flags equal the captured blank XOR `sync_cfg[1]` (bit 1 = blank inversion), on all three channels.
- R8: `sync_o[0]` (red) is enabled by `sync_cfg[3]`, `sync_o[1]` (green) by `sync_cfg[2]` and `sync_o[2]` (blue) by `sync_cfg[4]`. An enabled flag equals the captured composite sync XOR `sync_cfg[0]` (bit 0 = sync inversion). A disabled flag is 0, so sync has no effect when bits 4:2 are all zero.
- R9: `hsync_o` and `vsync_o` present the captured horizontal and vertical sync of the group, aligned with that group's pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pix | input | 1 | Fast pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seq_restart | input | 1 | Restart control bit; a rising transition restarts the sequence at A |
| sync_cfg | input | 5 | Bit 0 sync invert, bit 1 blank invert, bit 2 green sync enable, bit 3 red sync enable, bit 4 blue sync enable |
| load_in | input | 1 | Load strobe; a rising level captures a group |
| pix_word | input | 192 | Eight packed 24-bit RGB pixels |
| blank_in | input | 1 | Blank control, captured with the word |
| hsync_in | input | 1 | Horizontal sync, captured with the word |
| vsync_in | input | 1 | Vertical sync, captured with the word |
| csync_in | input | 1 | Composite sync, captured with the word |
| load_out | output | 1 | Divided load clock, pixel clock divided by eight |
| red_o | output | 8 | Red code of the current pixel |
| grn_o | output | 8 | Green code of the current pixel |
| blu_o | output | 8 | Blue code of the current pixel |
| blank_o | output | 3 | Blank flags, index 0 red, 1 green, 2 blue |
| sync_o | output | 3 | Sync flags, index 0 red, 1 green, 2 blue |
| hsync_o | output | 1 | Horizontal sync of the current group |
| vsync_o | output | 1 | Vertical sync of the current group |

## Verification
The assertions check the following on every cycle:
- the phase advances by one, or wraps, while running;
- a restart edge forces the phase back to A;
- the active group holds steady between boundaries;
- the idle outputs stay blank;
- blanked groups produce zero colour codes;
- the sync flags stay low whenever no channel is enabled.

Some behaviour only the bench's scenarios can show, because it is checked against a reference model on every clock:
- the actual pixel order and the packing of each pixel inside the word;
- which capture reaches the outputs when several land within one group;
- a restart in the middle of a group;
- the inversion and channel-routing combinations.

// File: rtl/pxs_pkg.sv
package pxs_pkg;

    // Captured per-group video controls
    typedef struct packed {
        logic blank;
        logic hsync;
        logic vsync;
        logic csync;
    } pxs_ctrl_t;

    // Configuration bit positions (decoded by the formatter)
    localparam int CFG_W         = 5;
    localparam int CFG_SYNC_INV  = 0;
    localparam int CFG_BLANK_INV = 1;
    localparam int CFG_EN_GRN    = 2;
    localparam int CFG_EN_RED    = 3;
    localparam int CFG_EN_BLU    = 4;

    // Output channel indices
    localparam int NUM_CH = 3;
    localparam int CH_RED = 0;
    localparam int CH_GRN = 1;
    localparam int CH_BLU = 2;

endpackage

// File: rtl/pxs_phase_ctrl.sv
module pxs_phase_ctrl #(
    parameter  int PIXELS = 8,
    localparam int PH_W   = $clog2(PIXELS)
) (
    input  logic            clk_pix,
    input  logic            rst_n,
    input  logic            seq_restart,
    output logic [PH_W-1:0] phase_o,
    output logic            armed_o,
    output logic            restart_rise_o,
    output logic            xfer_o,
    output logic            load_out_o
);

    localparam logic [PH_W-1:0] LAST = PH_W'(PIXELS - 1);
    localparam logic [PH_W-1:0] HALF = PH_W'(PIXELS / 2);

    typedef struct packed {
        logic [PH_W-1:0] phase;
        logic            armed;
        logic            restart_prev;
    } ph_state_t;

    ph_state_t st_d, st_q;
    logic      rise;

    always_comb begin
        st_d              = st_q;
        rise              = seq_restart & ~st_q.restart_prev;
        st_d.restart_prev = seq_restart;
        if (rise) begin
            st_d.phase = '0;
            st_d.armed = 1'b1;
        end else if (st_q.armed) begin
            if (st_q.phase == LAST) begin
                st_d.phase = '0;
            end else begin
                st_d.phase = st_q.phase + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_pix or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o        = st_q.phase;
    assign armed_o        = st_q.armed;
    assign restart_rise_o = rise;
    assign xfer_o         = rise | (st_q.armed & (st_q.phase == LAST));
    assign load_out_o     = st_q.armed & (st_q.phase < HALF);

endmodule

// File: rtl/pxs_group_buf.sv
module pxs_group_buf
    import pxs_pkg::*;
#(
    parameter  int PIXELS = 8,
    parameter  int CH_W   = 8,
    localparam int WORD_W = PIXELS * NUM_CH * CH_W
) (
    input  logic              clk_pix,
    input  logic              rst_n,
    input  logic              load_in,
    input  logic [WORD_W-1:0] word_in,
    input  pxs_ctrl_t         ctrl_in,
    input  logic              xfer,
    output logic [WORD_W-1:0] act_word_o,
    output pxs_ctrl_t         act_ctrl_o
);

    typedef struct packed {
        logic [WORD_W-1:0] cap_word;
        pxs_ctrl_t         cap_ctrl;
        logic [WORD_W-1:0] act_word;
        pxs_ctrl_t         act_ctrl;
        logic              load_prev;
    } buf_state_t;

    buf_state_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.load_prev = load_in;
        // capture stage: first sampled high level of the load strobe
        if (load_in && !st_q.load_prev) begin
            st_d.cap_word = word_in;
            st_d.cap_ctrl = ctrl_in;
        end
        // shift stage: refreshed only at a group boundary
        if (xfer) begin
            st_d.act_word = st_q.cap_word;
            st_d.act_ctrl = st_q.cap_ctrl;
        end
    end

    always_ff @(posedge clk_pix or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_word_o = st_q.act_word;
    assign act_ctrl_o = st_q.act_ctrl;

endmodule

// File: rtl/pxs_pixel_fmt.sv
module pxs_pixel_fmt
    import pxs_pkg::*;
#(
    parameter  int PIXELS = 8,
    parameter  int CH_W   = 8,
    localparam int PH_W   = $clog2(PIXELS),
    localparam int PIX_W  = NUM_CH * CH_W,
    localparam int WORD_W = PIXELS * PIX_W
) (
    input  logic              clk_pix,
    input  logic              rst_n,
    input  logic              armed,
    input  logic [PH_W-1:0]   phase,
    input  logic [WORD_W-1:0] act_word,
    input  pxs_ctrl_t         act_ctrl,
    input  logic [CFG_W-1:0]  sync_cfg,
    output logic [CH_W-1:0]   red_o,
    output logic [CH_W-1:0]   grn_o,
    output logic [CH_W-1:0]   blu_o,
    output logic [NUM_CH-1:0] blank_o,
    output logic [NUM_CH-1:0] sync_o,
    output logic              hsync_o,
    output logic              vsync_o
);

    typedef struct packed {
        logic [CH_W-1:0]   red;
        logic [CH_W-1:0]   grn;
        logic [CH_W-1:0]   blu;
        logic [NUM_CH-1:0] blank;
        logic [NUM_CH-1:0] sync;
        logic              hs;
        logic              vs;
    } fmt_state_t;

    logic [PIX_W-1:0]  pix [PIXELS];
    logic [PIX_W-1:0]  sel;
    logic [NUM_CH-1:0] sync_en;
    fmt_state_t        st_d, st_q;

    for (genvar g = 0; g < PIXELS; g++) begin : g_slice
        assign pix[g] = act_word[g*PIX_W +: PIX_W];
    end

    assign sel             = pix[phase];
    assign sync_en[CH_RED] = sync_cfg[CFG_EN_RED];
    assign sync_en[CH_GRN] = sync_cfg[CFG_EN_GRN];
    assign sync_en[CH_BLU] = sync_cfg[CFG_EN_BLU];

    always_comb begin
        st_d = st_q;
        if (!armed) begin
            st_d.red   = '0;
            st_d.grn   = '0;
            st_d.blu   = '0;
            st_d.blank = {NUM_CH{~sync_cfg[CFG_BLANK_INV]}};
            st_d.sync  = '0;
            st_d.hs    = 1'b0;
            st_d.vs    = 1'b0;
        end else begin
            if (act_ctrl.blank) begin
                st_d.red = '0;
                st_d.grn = '0;
                st_d.blu = '0;
            end else begin
                st_d.red = sel[3*CH_W-1 -: CH_W];
                st_d.grn = sel[2*CH_W-1 -: CH_W];
                st_d.blu = sel[CH_W-1 -: CH_W];
            end
            st_d.blank = {NUM_CH{act_ctrl.blank ^ sync_cfg[CFG_BLANK_INV]}};
            st_d.sync  = sync_en & {NUM_CH{act_ctrl.csync ^ sync_cfg[CFG_SYNC_INV]}};
            st_d.hs    = act_ctrl.hsync;
            st_d.vs    = act_ctrl.vsync;
        end
    end

    always_ff @(posedge clk_pix or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.blank <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign red_o   = st_q.red;
    assign grn_o   = st_q.grn;
    assign blu_o   = st_q.blu;
    assign blank_o = st_q.blank;
    assign sync_o  = st_q.sync;
    assign hsync_o = st_q.hs;
    assign vsync_o = st_q.vs;

endmodule

// File: rtl/pixel_serializer.sv
module pixel_serializer
    import pxs_pkg::*;
#(
    parameter  int PIXELS = 8,
    parameter  int CH_W   = 8,
    localparam int PH_W   = $clog2(PIXELS),
    localparam int WORD_W = PIXELS * NUM_CH * CH_W
) (
    input  logic              clk_pix,
    input  logic              rst_n,
    input  logic              seq_restart,
    input  logic [CFG_W-1:0]  sync_cfg,
    input  logic              load_in,
    input  logic [WORD_W-1:0] pix_word,
    input  logic              blank_in,
    input  logic              hsync_in,
    input  logic              vsync_in,
    input  logic              csync_in,
    output logic              load_out,
    output logic [CH_W-1:0]   red_o,
    output logic [CH_W-1:0]   grn_o,
    output logic [CH_W-1:0]   blu_o,
    output logic [NUM_CH-1:0] blank_o,
    output logic [NUM_CH-1:0] sync_o,
    output logic              hsync_o,
    output logic              vsync_o
);

    logic [PH_W-1:0]   phase_w;
    logic              armed_w;
    logic              restart_rise_w;
    logic              xfer_w;
    logic [WORD_W-1:0] act_word_w;
    pxs_ctrl_t         act_ctrl_w;
    pxs_ctrl_t         ctrl_in_w;

    assign ctrl_in_w = '{blank: blank_in, hsync: hsync_in,
                         vsync: vsync_in, csync: csync_in};

    pxs_phase_ctrl #(.PIXELS(PIXELS)) i_phase (
        .clk_pix       (clk_pix),
        .rst_n         (rst_n),
        .seq_restart   (seq_restart),
        .phase_o       (phase_w),
        .armed_o       (armed_w),
        .restart_rise_o(restart_rise_w),
        .xfer_o        (xfer_w),
        .load_out_o    (load_out)
    );

    pxs_group_buf #(.PIXELS(PIXELS), .CH_W(CH_W)) i_buf (
        .clk_pix   (clk_pix),
        .rst_n     (rst_n),
        .load_in   (load_in),
        .word_in   (pix_word),
        .ctrl_in   (ctrl_in_w),
        .xfer      (xfer_w),
        .act_word_o(act_word_w),
        .act_ctrl_o(act_ctrl_w)
    );

    pxs_pixel_fmt #(.PIXELS(PIXELS), .CH_W(CH_W)) i_fmt (
        .clk_pix (clk_pix),
        .rst_n   (rst_n),
        .armed   (armed_w),
        .phase   (phase_w),
        .act_word(act_word_w),
        .act_ctrl(act_ctrl_w),
        .sync_cfg(sync_cfg),
        .red_o   (red_o),
        .grn_o   (grn_o),
        .blu_o   (blu_o),
        .blank_o (blank_o),
        .sync_o  (sync_o),
        .hsync_o (hsync_o),
        .vsync_o (vsync_o)
    );

endmodule

// File: rtl/pxs_checker.sv
module pxs_checker #(
    parameter  int PIXELS = 8,
    parameter  int CH_W   = 8,
    localparam int PH_W   = $clog2(PIXELS),
    localparam int WORD_W = PIXELS * 3 * CH_W
) (
    input logic              clk_pix,
    input logic              rst_n,
    input logic              armed,
    input logic              restart_rise,
    input logic [PH_W-1:0]   phase,
    input logic [WORD_W-1:0] act_word,
    input logic              act_blank,
    input logic [4:0]        sync_cfg,
    input logic              load_out,
    input logic [CH_W-1:0]   red_o,
    input logic [CH_W-1:0]   grn_o,
    input logic [CH_W-1:0]   blu_o,
    input logic [2:0]        sync_o
);

    localparam logic [PH_W-1:0] LAST = PH_W'(PIXELS - 1);

    // Idle: nothing but blanking leaves the block
    assert_idle_quiet_R1: assert property (@(posedge clk_pix) disable iff (!rst_n)
        !armed |-> (red_o == '0 && grn_o == '0 && blu_o == '0 &&
                    sync_o == '0 && !load_out && phase == '0));

    // Running phase steps by one
    assert_phase_step_R3: assert property (@(posedge clk_pix) disable iff (!rst_n)
        (armed && !restart_rise && phase != LAST) |=> (phase == $past(phase) + 1'b1));

    // Running phase wraps after the last pixel
    assert_phase_wrap_R3: assert property (@(posedge clk_pix) disable iff (!rst_n)
        (armed && !restart_rise && phase == LAST) |=> (phase == '0));

    // Restart edge returns to pixel A
    assert_restart_to_a_R4: assert property (@(posedge clk_pix) disable iff (!rst_n)
        restart_rise |=> (armed && phase == '0));

    // Active group stays put between boundaries
    assert_group_hold_R6: assert property (@(posedge clk_pix) disable iff (!rst_n)
        (!restart_rise && !(armed && phase == LAST)) |=> $stable(act_word));

    // Blanked group yields zero colour codes
    assert_blank_zero_R7: assert property (@(posedge clk_pix) disable iff (!rst_n)
        (armed && act_blank) |=> (red_o == '0 && grn_o == '0 && blu_o == '0));

    // No channel enabled: sync never reaches the outputs
    assert_sync_ignored_R8: assert property (@(posedge clk_pix) disable iff (!rst_n)
        (sync_cfg[4:2] == 3'b000) |=> (sync_o == 3'b000));

endmodule

bind pixel_serializer pxs_checker #(.PIXELS(PIXELS), .CH_W(CH_W)) i_pxs_checker (
    .clk_pix     (clk_pix),
    .rst_n       (rst_n),
    .armed       (armed_w),
    .restart_rise(restart_rise_w),
    .phase       (phase_w),
    .act_word    (act_word_w),
    .act_blank   (act_ctrl_w.blank),
    .sync_cfg    (sync_cfg),
    .load_out    (load_out),
    .red_o       (red_o),
    .grn_o       (grn_o),
    .blu_o       (blu_o),
    .sync_o      (sync_o)
);

// File: tb/test_pixel_serializer.sv
`timescale 1ns/1ps
module test_pixel_serializer;

    localparam int NPIX   = 8;
    localparam int WORD_W = 192;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              seq_restart = 1'b0;
    logic [4:0]        sync_cfg = 5'b0;
    logic              load_in = 1'b0;
    logic [WORD_W-1:0] pix_word = '0;
    logic              blank_in = 1'b0, hsync_in = 1'b0, vsync_in = 1'b0, csync_in = 1'b0;
    logic              load_out;
    logic [7:0]        red_o, grn_o, blu_o;
    logic [2:0]        blank_o, sync_o;
    logic              hsync_o, vsync_o;

    always #4 clk = ~clk;   // 125 MHz

    pixel_serializer i_pixel_serializer (
        .clk_pix(clk), .rst_n(rst_n), .seq_restart(seq_restart), .sync_cfg(sync_cfg),
        .load_in(load_in), .pix_word(pix_word), .blank_in(blank_in),
        .hsync_in(hsync_in), .vsync_in(vsync_in), .csync_in(csync_in),
        .load_out(load_out), .red_o(red_o), .grn_o(grn_o), .blu_o(blu_o),
        .blank_o(blank_o), .sync_o(sync_o), .hsync_o(hsync_o), .vsync_o(vsync_o)
    );

    // ---------------- reference model ----------------
    int              vectors = 0;
    int              miscompares = 0;
    bit              finished = 0;
    string           scen = "R1";

    bit              m_prev_ld = 0, m_prev_rs = 0, m_armed = 0;
    int              m_phase = 0;
    logic [WORD_W-1:0] m_cap_w = '0, m_act_w = '0;
    logic [3:0]      m_cap_c = '0, m_act_c = '0;   // {blank,hs,vs,cs}

    logic [7:0]      e_r = 0, e_g = 0, e_b = 0;
    logic [2:0]      e_blank = 3'b111, e_sync = 0;
    logic            e_hs = 0, e_vs = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_prev_ld = 0; m_prev_rs = 0; m_armed = 0; m_phase = 0;
            m_cap_w = '0; m_act_w = '0; m_cap_c = '0; m_act_c = '0;
            e_r = 0; e_g = 0; e_b = 0; e_blank = 3'b111; e_sync = 0; e_hs = 0; e_vs = 0;
        end else begin
            bit rs_rise, ld_rise;
            logic [23:0] px;
            rs_rise = seq_restart && !m_prev_rs;
            ld_rise = load_in && !m_prev_ld;
            // outputs produced at this edge
            if (!m_armed) begin
                e_r = 0; e_g = 0; e_b = 0;
                e_blank = {3{~sync_cfg[1]}};
                e_sync = 0; e_hs = 0; e_vs = 0;
            end else begin
                px = m_act_w[m_phase*24 +: 24];
                e_r = m_act_c[3] ? 8'h00 : px[23:16];
                e_g = m_act_c[3] ? 8'h00 : px[15:8];
                e_b = m_act_c[3] ? 8'h00 : px[7:0];
                e_blank = {3{m_act_c[3] ^ sync_cfg[1]}};
                e_sync[0] = sync_cfg[3] & (m_act_c[0] ^ sync_cfg[0]);
                e_sync[1] = sync_cfg[2] & (m_act_c[0] ^ sync_cfg[0]);
                e_sync[2] = sync_cfg[4] & (m_act_c[0] ^ sync_cfg[0]);
                e_hs = m_act_c[2]; e_vs = m_act_c[1];
            end
            // sequencing state
            if (rs_rise) begin
                m_armed = 1; m_phase = 0; m_act_w = m_cap_w; m_act_c = m_cap_c;
            end else if (m_armed) begin
                if (m_phase == NPIX - 1) begin
                    m_act_w = m_cap_w; m_act_c = m_cap_c; m_phase = 0;
                end else begin
                    m_phase = m_phase + 1;
                end
            end
            if (ld_rise) begin
                m_cap_w = pix_word;
                m_cap_c = {blank_in, hsync_in, vsync_in, csync_in};
            end
            m_prev_ld = load_in; m_prev_rs = seq_restart;
        end
    end

    task automatic miss(input string tag, input string what, input int act, input int exp);
        miscompares++;
        $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    endtask

    // compare away from the active edge
    always @(negedge clk) begin
        if (!finished) begin
            string ctag;
            bit    e_lo;
            e_lo = m_armed && (m_phase < NPIX / 2);
            ctag = !m_armed ? "R1" : (e_blank != {3{sync_cfg[1]}} && m_act_c[3]) ? "R7" : scen;
            vectors++;
            if (red_o !== e_r)   miss(ctag, "red_o", red_o, e_r);
            if (grn_o !== e_g)   miss(ctag, "grn_o", grn_o, e_g);
            if (blu_o !== e_b)   miss(ctag, "blu_o", blu_o, e_b);
            if (blank_o !== e_blank) miss(m_armed ? "R7" : "R1", "blank_o", blank_o, e_blank);
            if (sync_o !== e_sync)   miss(m_armed ? "R8" : "R1", "sync_o", sync_o, e_sync);
            if (load_out !== e_lo)   miss("R5", "load_out", load_out, e_lo);
            if (hsync_o !== e_hs)    miss("R9", "hsync_o", hsync_o, e_hs);
            if (vsync_o !== e_vs)    miss("R9", "vsync_o", vsync_o, e_vs);
        end
    end

    // ---------------- stimulus ----------------
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic new_group(input int blank_pct);
        for (int i = 0; i < 6; i++) pix_word[i*32 +: 32] = $urandom;
        blank_in = (($urandom % 100) < blank_pct);
        hsync_in = $urandom % 2;
        vsync_in = $urandom % 2;
        csync_in = $urandom % 2;
    endtask

    // groups of 'period' cycles, load strobe high for 'hi' cycles
    task automatic run_groups(input int n, input int period, input int hi, input int blank_pct);
        for (int g = 0; g < n; g++) begin
            new_group(blank_pct);
            for (int c = 0; c < period; c++) begin
                load_in = (c < hi);
                step();
            end
        end
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        // R1: idle with traffic on the load strobe, no restart edge yet
        scen = "R1";
        run_groups(3, 8, 4, 0);
        sync_cfg = 5'b00010;            // R1: idle blank level follows inversion bit
        run_groups(1, 8, 4, 0);
        sync_cfg = 5'b11100;
        // R2 / R3: start the sequence, stream groups
        scen = "R3";
        seq_restart = 1'b1;
        run_groups(6, 8, 4, 0);
        scen = "R2";
        run_groups(4, 8, 1, 0);
        // R7 / R8: inversion and routing combinations with blanking
        scen = "R8";
        sync_cfg = 5'b00000; run_groups(4, 8, 4, 40);   // sync ignored
        sync_cfg = 5'b01001; run_groups(4, 8, 4, 40);   // red only, inverted
        sync_cfg = 5'b10110; run_groups(4, 8, 4, 40);   // green+blue, blank inverted
        sync_cfg = 5'b00111; run_groups(4, 8, 4, 40);
        scen = "R7";
        sync_cfg = 5'b11111; run_groups(4, 8, 4, 100);
        // R6: captures land mid-group, several per group
        scen = "R6";
        sync_cfg = 5'b11100;
        step(); step(); step();
        run_groups(8, 4, 2, 20);
        run_groups(6, 3, 1, 20);
        // R4: restart in the middle of a group
        scen = "R4";
        for (int k = 0; k < 5; k++) begin
            seq_restart = 1'b0;
            run_groups(1, 3 + k, 1, 20);
            seq_restart = 1'b1;
            run_groups(2, 8, 4, 20);
        end
        // R4: restart held high has no further effect
        run_groups(3, 8, 4, 20);
        repeat (4) step();
        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            finished = 1;
            miscompares++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule